// File: doc/BRIEF.md
# Configurable Aspect-Ratio Block RAM

This block is a 16,384-bit clocked memory tile whose shape is chosen by a static mode code. The same fixed set of pins serves nine organisations. Five are single-port: 1024x16, 2048x8, 4096x4, 8192x2 and 16384x1. Four are dual-port: 2048x8, 4096x4, 8192x2 and 16384x1. In dual-port operation the shared 16-bit data-in and data-out buses are split into two adjacent lanes, one per port.

All shapes map onto one linear bit store. A word `a` of width `W` occupies bits `a*W` to `a*W+W-1`, so data written under one shape reads back predictably under another. Reads are synchronous with one cycle of latency and return the contents from before any write in the same cycle. The mode is meant to stay constant during normal operation.

Top module: `ar_ram_tile`

## Requirements
- R1: `mode_sel` encodes the shape as follows. 0 is 1024x16, 1 is 2048x8, 2 is 4096x4, 3 is 8192x2 and 4 is 16384x1, all single-port. 5 is 2048x8, 6 is 4096x4, 7 is 8192x2 and 8 is 16384x1, all dual-port.
- R2: For a shape of depth 2^N, port A uses only `addr_a[N-1:0]` and port B uses only `addr_b[N-1:0]`. Higher address bits do not affect which word is accessed.
- R3: In a single-port shape of width W, port A writes `din[W-1:0]` when `we_a` is high and reads to `dout[W-1:0]`. `addr_b`, `we_b` and `din[15:W]` have no effect, and `dout[15:W]` is zero.
- R4: In a dual-port shape of width W, port A uses lane `din`/`dout[W-1:0]` with `we_a`. Port B uses lane `din`/`dout[2W-1:W]` with `we_b`. `dout[15:2W]` is zero.
- R5: Read data for the address presented at a clock edge appears on `dout` after that edge and holds until the next edge. A write in the same cycle does not change that read data, so the old contents are returned.
- R6: Word `a` at width W is stored in linear bits `a*W` to `a*W+W-1`, with lane bit 0 in the lowest of these. Contents are preserved across mode changes.
- R7: When both ports write the same word in the same cycle, port B's data is stored. A port that reads a word the other port writes in that cycle returns the old contents.
- R8: Mode codes 9 to 15 are invalid. Under an invalid code no write takes effect and `dout` is zero one cycle later.
- R9: `rst_n` is a synchronous active-low reset. It forces `dout` to zero on the following cycle and blocks writes while it is low. It does not clear the stored contents.
- R10: A port whose write enable is low leaves the storage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage and read registers |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 4 | Static shape and port-count code (R1) |
| addr_a | input | 14 | Port A word address |
| addr_b | input | 14 | Port B word address (dual-port shapes only) |
| din | input | 16 | Shared write data, split into lanes in dual-port shapes |
| we_a | input | 1 | Port A write enable |
| we_b | input | 1 | Port B write enable (dual-port shapes only) |
| dout | output | 16 | Shared read data, split into lanes in dual-port shapes |

## Verification
Every result of this block is due exactly one clock edge after it is requested. This covers read data, the zeroing under reset and the zeroing under an invalid mode. A write becomes visible to a read presented on the following edge, never on the same one. The bench applies each operation at a falling edge and computes the expected read word from its bit model before applying that operation's writes to the model. It then compares `dout` at the next falling edge, half a period after the capturing edge. The comparison therefore sees exactly one register stage and the read-first ordering.

// File: rtl/ar_ram_pkg.sv
// Package: shared types for the configurable aspect-ratio RAM tile.
// Assumes widths of at most 2**31 bits (lw field is 5 bits wide).
package ar_ram_pkg;

    // Decoded shape: validity, port count and log2 of the word width.
    typedef struct packed {
        logic       valid;
        logic       dual;
        logic [4:0] lw;
    } ar_cfg_t;

    // Mode codes used by the default 16-bit tile.
    typedef enum logic [3:0] {
        AR_SP16 = 4'd0,
        AR_SP8  = 4'd1,
        AR_SP4  = 4'd2,
        AR_SP2  = 4'd3,
        AR_SP1  = 4'd4,
        AR_DP8  = 4'd5,
        AR_DP4  = 4'd6,
        AR_DP2  = 4'd7,
        AR_DP1  = 4'd8
    } ar_mode_e;

endpackage

// File: rtl/ar_mode_dec.sv
// Module: decodes the static mode code into a shape descriptor.
// Codes 0..MAX_LW are single-port, widest first. Codes MAX_LW+1..2*MAX_LW are
// dual-port, starting at half width. Any higher code is invalid.
// Assumes the mode code is held steady during normal operation.
module ar_mode_dec
    import ar_ram_pkg::*;
#(
    parameter int MODE_W = 4,
    parameter int MAX_LW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output ar_cfg_t           cfg_o
);

    // Map the code onto validity, dual flag and log2 width.
    always_comb begin
        cfg_o = '0;
        if (int'(mode_i) <= MAX_LW) begin
            cfg_o.valid = 1'b1;
            cfg_o.dual  = 1'b0;
            cfg_o.lw    = 5'(MAX_LW - int'(mode_i));
        end else if (int'(mode_i) <= 2 * MAX_LW) begin
            cfg_o.valid = 1'b1;
            cfg_o.dual  = 1'b1;
            cfg_o.lw    = 5'(2 * MAX_LW - int'(mode_i));
        end
    end

    // R1: a dual-port shape never uses the full data width.
    a_r1_dual_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o.dual |-> (int'(cfg_o.lw) < MAX_LW));

    // R1: every valid shape keeps its word width within the bus.
    a_r1_width_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o.valid |-> (int'(cfg_o.lw) <= MAX_LW));

endmodule

// File: rtl/ar_port_map.sv
// Module: steers one port's pins onto the shared bit store.
// Turns a word address into a row index and a bit offset within the row.
// Picks this port's data lane and builds the row-aligned write mask and data.
// Assumes DATA_W is a power of two and that the row width equals DATA_W.
module ar_port_map
    import ar_ram_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int LANE   = 0,
    localparam int MAX_LW = $clog2(DATA_W),
    localparam int ROW_AW = ADDR_W - MAX_LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ar_cfg_t           cfg_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [ROW_AW-1:0] row_o,
    output logic [MAX_LW-1:0] off_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_o
);

    logic [ADDR_W-1:0] bit_addr;
    logic [DATA_W-1:0] lo_mask;
    logic [DATA_W-1:0] lane_data;
    int                width;

    // Linear bit address: the word index scaled by the width, dropping high bits.
    always_comb begin
        width    = 1 << cfg_i.lw;
        bit_addr = ADDR_W'(addr_i << cfg_i.lw);
        row_o    = bit_addr[ADDR_W-1:MAX_LW];
        off_o    = bit_addr[MAX_LW-1:0];
    end

    // Lane extraction and alignment of write data and mask within the row.
    always_comb begin
        lo_mask   = (DATA_W'(1) << width) - DATA_W'(1);
        lane_data = (din_i >> (LANE * width)) & lo_mask;
        mask_o    = lo_mask << off_o;
        wdata_o   = lane_data << off_o;
    end

    // Write strobe: valid shape, reset released, and for port B a dual shape.
    always_comb begin
        wr_o = we_i & en_i & cfg_i.valid & ((LANE == 0) ? 1'b1 : cfg_i.dual);
    end

    // R6: the mask covers exactly one word of the selected width.
    a_r6_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.valid |-> ($countones(mask_o) == width));

    // R6: words start on a multiple of their own width.
    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.valid |-> ((int'(off_o) % width) == 0));

    // R3: port B never writes in a single-port shape.
    a_r3_no_b_write: assert property (@(posedge clk) disable iff (!rst_n)
        (LANE != 0 && !cfg_i.dual) |-> !wr_o);

endmodule

// File: rtl/ar_bit_array.sv
// Module: row-organised storage with two read-modify-write ports.
// Each row is DATA_W bits wide. A port writes only the bits set in its mask.
// When both ports hit one row, the two updates merge and port B wins any
// overlapping bits. Reads register the whole row before any write (read-first).
// Storage is not reset.
module ar_bit_array #(
    parameter int ROW_AW = 10,
    parameter int DATA_W = 16,
    localparam int ROWS  = 1 << ROW_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr1_i,
    input  logic [ROW_AW-1:0] row1_i,
    input  logic [DATA_W-1:0] mask1_i,
    input  logic [DATA_W-1:0] wdata1_i,
    input  logic              wr2_i,
    input  logic [ROW_AW-1:0] row2_i,
    input  logic [DATA_W-1:0] mask2_i,
    input  logic [DATA_W-1:0] wdata2_i,
    output logic [DATA_W-1:0] rd1_q,
    output logic [DATA_W-1:0] rd2_q
);

    logic [DATA_W-1:0] mem [ROWS];
    logic              same_row;
    logic [DATA_W-1:0] row1_new;
    logic [DATA_W-1:0] row2_base;
    logic [DATA_W-1:0] row2_new;

    // Next row values, merging both ports when they share a row.
    always_comb begin
        same_row  = (row1_i == row2_i);
        row1_new  = (mem[row1_i] & ~mask1_i) | (wdata1_i & mask1_i);
        row2_base = (wr1_i && same_row) ? row1_new : mem[row2_i];
        row2_new  = (row2_base & ~mask2_i) | (wdata2_i & mask2_i);
    end

    // Storage update; port B's merged write covers a shared row.
    always_ff @(posedge clk) begin
        if (wr1_i && !(wr2_i && same_row)) begin
            mem[row1_i] <= row1_new;
        end
        if (wr2_i) begin
            mem[row2_i] <= row2_new;
        end
    end

    // Read registers capture contents from before this edge's writes.
    always_ff @(posedge clk) begin
        rd1_q <= mem[row1_i];
        rd2_q <= mem[row2_i];
    end

    // R7: on a shared row, port B's bits are what is stored.
    a_r7_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_i && wr2_i && same_row) |=>
        ((mem[$past(row2_i)] & $past(mask2_i)) == ($past(wdata2_i) & $past(mask2_i))));

    // R10: with no write strobes, the addressed row keeps its contents.
    a_r10_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr1_i && !wr2_i) |=> (mem[$past(row1_i)] == $past(mem[row1_i])));

    // R5: the registered read equals the row contents before the write.
    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd1_q == $past(mem[row1_i])));

endmodule

// File: rtl/ar_out_steer.sv
// Module: registers the read shape and offsets, then extracts each port's
// word from its registered row and places it in its output lane.
// Lanes that the shape does not use are zero, and the whole bus is zero for
// an invalid shape. Assumes the read rows come from registers that capture
// on the same edge.
module ar_out_steer
    import ar_ram_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int MAX_LW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ar_cfg_t           cfg_i,
    input  logic [MAX_LW-1:0] off1_i,
    input  logic [MAX_LW-1:0] off2_i,
    input  logic [DATA_W-1:0] rd1_i,
    input  logic [DATA_W-1:0] rd2_i,
    output logic [DATA_W-1:0] dout_o
);

    ar_cfg_t           cfg_q;
    logic [MAX_LW-1:0] off1_q;
    logic [MAX_LW-1:0] off2_q;
    logic [DATA_W-1:0] lo_mask;
    logic [DATA_W-1:0] word1;
    logic [DATA_W-1:0] word2;
    int                width;

    // Capture the shape alongside the read rows; reset selects an invalid shape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            off1_q <= '0;
            off2_q <= '0;
        end else begin
            cfg_q  <= cfg_i;
            off1_q <= off1_i;
            off2_q <= off2_i;
        end
    end

    // Extract both words and assemble the output lanes.
    always_comb begin
        width   = 1 << cfg_q.lw;
        lo_mask = (DATA_W'(1) << width) - DATA_W'(1);
        word1   = (rd1_i >> off1_q) & lo_mask;
        word2   = (rd2_i >> off2_q) & lo_mask;
        if (!cfg_q.valid) begin
            dout_o = '0;
        end else if (cfg_q.dual) begin
            dout_o = word1 | (word2 << width);
        end else begin
            dout_o = word1;
        end
    end

endmodule

// File: rtl/ar_ram_tile.sv
// Module: top of the configurable aspect-ratio RAM tile.
// Decodes the mode, steers both ports onto one row-organised bit store and
// formats the read data. Assumes mode_sel changes only while the tile is idle.
module ar_ram_tile
    import ar_ram_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int MODE_W = 4,
    localparam int MAX_LW = $clog2(DATA_W),
    localparam int ROW_AW = ADDR_W - MAX_LW,
    localparam int NPORT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din,
    input  logic              we_a,
    input  logic              we_b,
    output logic [DATA_W-1:0] dout
);

    ar_cfg_t           cfg_c;
    logic [ADDR_W-1:0] addr_v  [NPORT];
    logic              we_v    [NPORT];
    logic [ROW_AW-1:0] row_v   [NPORT];
    logic [MAX_LW-1:0] off_v   [NPORT];
    logic [DATA_W-1:0] mask_v  [NPORT];
    logic [DATA_W-1:0] wdata_v [NPORT];
    logic              wr_v    [NPORT];
    logic [DATA_W-1:0] rd1_q;
    logic [DATA_W-1:0] rd2_q;

    // Gather per-port pins into arrays for the generated port maps.
    always_comb begin
        addr_v[0] = addr_a;
        addr_v[1] = addr_b;
        we_v[0]   = we_a;
        we_v[1]   = we_b;
    end

    ar_mode_dec #(
        .MODE_W (MODE_W),
        .MAX_LW (MAX_LW)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_sel),
        .cfg_o  (cfg_c)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ar_port_map #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .LANE   (p)
        ) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_i   (cfg_c),
            .en_i    (rst_n),
            .addr_i  (addr_v[p]),
            .we_i    (we_v[p]),
            .din_i   (din),
            .row_o   (row_v[p]),
            .off_o   (off_v[p]),
            .mask_o  (mask_v[p]),
            .wdata_o (wdata_v[p]),
            .wr_o    (wr_v[p])
        );
    end

    ar_bit_array #(
        .ROW_AW (ROW_AW),
        .DATA_W (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr1_i    (wr_v[0]),
        .row1_i   (row_v[0]),
        .mask1_i  (mask_v[0]),
        .wdata1_i (wdata_v[0]),
        .wr2_i    (wr_v[1]),
        .row2_i   (row_v[1]),
        .mask2_i  (mask_v[1]),
        .wdata2_i (wdata_v[1]),
        .rd1_q    (rd1_q),
        .rd2_q    (rd2_q)
    );

    ar_out_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (cfg_c),
        .off1_i (off_v[0]),
        .off2_i (off_v[1]),
        .rd1_i  (rd1_q),
        .rd2_i  (rd2_q),
        .dout_o (dout)
    );

    // R8: an invalid code held over an edge yields a zero bus.
    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_c.valid && $stable(mode_sel)) |-> (dout == '0));

    // R3: bits above the word are zero in a steady single-port shape.
    a_r3_sp_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_c.valid && !cfg_c.dual && $stable(mode_sel)) |->
        ((dout >> (1 << cfg_c.lw)) == '0));

    // R4: bits above both lanes are zero in a steady dual-port shape.
    a_r4_dp_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_c.dual && $stable(mode_sel)) |->
        ((dout >> (2 << cfg_c.lw)) == '0));

    // R9: the first cycle after reset shows a zero bus.
    a_r9_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dout == '0));

endmodule

// File: tb/ar_ram_tile_tb_top.sv
// Bench: random and directed operations checked against a bit-level model.
module ar_ram_tile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_sel = 4'd0;
    logic [13:0] addr_a = '0;
    logic [13:0] addr_b = '0;
    logic [15:0] din = '0;
    logic        we_a = 1'b0;
    logic        we_b = 1'b0;
    logic [15:0] dout;

    logic [16383:0] mdl;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ar_ram_tile dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .addr_a   (addr_a),
        .addr_b   (addr_b),
        .din      (din),
        .we_a     (we_a),
        .we_b     (we_b),
        .dout     (dout)
    );

    // log2 width per mode code, -1 for invalid (R1)
    function automatic int mode_lw(int m);
        if (m <= 4) return 4 - m;
        if (m <= 8) return 8 - m;
        return -1;
    endfunction

    function automatic bit mode_dual(int m);
        return (m >= 5 && m <= 8);
    endfunction

    function automatic logic [15:0] model_rd(int lw, int a);
        logic [15:0] v = '0;
        int w = 1 << lw;
        int aa = a & ((1 << (14 - lw)) - 1);
        for (int b = 0; b < w; b++) v[b] = mdl[aa * w + b];
        return v;
    endfunction

    function automatic logic [15:0] model_out(int m, int a1, int a2);
        int lw = mode_lw(m);
        logic [15:0] v;
        if (lw < 0) return 16'h0;
        v = model_rd(lw, a1);
        if (mode_dual(m)) v = v | (model_rd(lw, a2) << (1 << lw));
        return v;
    endfunction

    task automatic model_wr(int lw, int a, logic [15:0] d);
        int w = 1 << lw;
        int aa = a & ((1 << (14 - lw)) - 1);
        for (int b = 0; b < w; b++) mdl[aa * w + b] = d[b];
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h (mode %0d)", tag, act, exp, mode_sel);
        end
    endtask

    // One operation: called at a falling edge, checks dout at the next one.
    task automatic op(int m, int a1, int a2, logic [15:0] d, bit w1, bit w2,
                      bit chk, string tag);
        int lw = mode_lw(m);
        logic [15:0] exp;
        mode_sel = 4'(m);
        addr_a = 14'(a1);
        addr_b = 14'(a2);
        din = d;
        we_a = w1;
        we_b = w2;
        exp = model_out(m, a1, a2);
        if (lw >= 0) begin
            if (w1) model_wr(lw, a1, d & 16'((1 << (1 << lw)) - 1));
            if (w2 && mode_dual(m))
                model_wr(lw, a2, (d >> (1 << lw)) & 16'((1 << (1 << lw)) - 1));
        end
        @(negedge clk);
        if (chk) check(tag, dout, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        // R9: output is zero while and right after reset
        check("R9 reset", dout, 16'h0);
        rst_n = 1'b1;

        // Fill the whole store through the widest shape.
        for (int a = 0; a < 1024; a++) op(0, a, 0, 16'($urandom), 1'b1, 1'b0, 1'b0, "init");
        op(0, 0, 0, 16'h0, 1'b0, 1'b0, 1'b0, "init");

        // Random traffic in every valid shape (R1, R2 via random high address bits).
        for (int m = 0; m <= 8; m++) begin
            for (int i = 0; i < 150; i++) begin
                op(m, int'($urandom % 16384), int'($urandom % 16384), 16'($urandom),
                   1'($urandom), 1'($urandom), 1'b1,
                   mode_dual(m) ? "R1 R4 R5 R10 dual" : "R1 R3 R5 R10 single");
            end
        end

        // R2: high address bits alias onto the same word
        op(0, 5, 0, 16'hBEEF, 1'b1, 1'b0, 1'b0, "R2");
        op(0, 14'h3C05, 0, 16'h0, 1'b0, 1'b0, 1'b1, "R2 alias");
        check("R2 alias value", dout, 16'hBEEF);

        // R5: read-first on a write to the same address
        op(2, 9, 0, 16'h0003, 1'b1, 1'b0, 1'b1, "R5 old data");
        op(2, 9, 0, 16'h000C, 1'b1, 1'b0, 1'b1, "R5 old data");
        check("R5 value", dout, 16'h0003);

        // R3: addr_b / we_b / upper din ignored in single-port shape
        op(1, 100, 200, 16'hFF5A, 1'b1, 1'b1, 1'b0, "R3");
        op(1, 100, 200, 16'h0000, 1'b0, 1'b0, 1'b1, "R3 ignore");
        op(1, 200, 0, 16'h0000, 1'b0, 1'b0, 1'b1, "R3 port B untouched");

        // R7: both ports write one word, port B wins; reads return old contents
        op(6, 37, 37, 16'h00A5, 1'b1, 1'b1, 1'b1, "R7 collide");
        op(6, 37, 37, 16'h0000, 1'b0, 1'b0, 1'b1, "R7 collide");
        check("R7 B wins", dout, 16'h00AA);
        op(6, 40, 40, 16'h0070, 1'b0, 1'b1, 1'b1, "R7 cross read");
        op(6, 40, 41, 16'h0000, 1'b0, 1'b0, 1'b1, "R7 cross read");

        // R6: bits written one at a time read back as a 16-bit word
        for (int b = 0; b < 16; b++)
            op(4, 16 + b, 0, 16'((16'hC3A1 >> b) & 1), 1'b1, 1'b0, 1'b0, "R6");
        op(0, 1, 0, 16'h0, 1'b0, 1'b0, 1'b1, "R6 cross shape");
        check("R6 value", dout, 16'hC3A1);
        op(3, 8, 0, 16'h0, 1'b0, 1'b0, 1'b1, "R6 2-bit view");

        // R10: write enable low leaves contents unchanged
        op(0, 2, 0, 16'h1234, 1'b1, 1'b0, 1'b0, "R10");
        op(0, 2, 0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R10");
        op(0, 2, 0, 16'h0, 1'b0, 1'b0, 1'b1, "R10 no write");
        check("R10 value", dout, 16'h1234);

        // R8: invalid codes block writes and zero the bus
        op(12, 3, 3, 16'hFFFF, 1'b1, 1'b1, 1'b1, "R8 zero");
        op(15, 3, 3, 16'hFFFF, 1'b1, 1'b1, 1'b1, "R8 zero");
        op(0, 3, 0, 16'h0, 1'b0, 1'b0, 1'b1, "R8 no write");

        // R9: reset mid-run zeroes output and keeps contents
        rst_n = 1'b0;
        we_a = 1'b1;
        addr_a = 14'd2;
        din = 16'h5555;
        @(negedge clk);
        check("R9 mid reset", dout, 16'h0);
        rst_n = 1'b1;
        op(0, 2, 0, 16'h0, 1'b0, 1'b0, 1'b1, "R9 contents kept");
        check("R9 value", dout, 16'h1234);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule